// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the main arithmetic unit of a small accumulator processor. It takes the accumulator value, a second operand and a 3-bit operation code, and it returns the next accumulator value. It also returns the carry that would follow from the operation. The operand is chosen outside the block and can be an immediate byte or a register value. The result path is purely combinational, so the core can compute the result and write it into its accumulator in the execute state of the same cycle.

The carry flag is the only state inside the block. It is a single flop that loads the computed carry on a clock edge when the core asserts the flag write enable. Add always folds in the stored carry. Clearing and setting the carry are ALU operations that leave the accumulator value unchanged. A separate output tells the jump-on-zero logic whether the accumulator value presented to the block is zero.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, and after it is released with no flag write, carry_o is 0.
- R2: Operation code 1 (add with carry) gives {carry_nxt_o, res_o} = acc_i + opnd_i + carry_o as a (W+1)-bit sum. The top bit is the new carry.
- R3: Operation codes 2, 3 and 4 give res_o equal to acc_i OR, AND and XOR opnd_i, bit by bit.
- R4: Operation code 5 gives res_o = {acc_i[W/2-1:0], acc_i[W-1:W/2]}, which swaps the lower and upper halves.
- R5: Operation code 6 gives carry_nxt_o = 0, and operation code 7 gives carry_nxt_o = 1. For both, res_o equals acc_i.
- R6: Operation code 0 (pass) gives res_o = opnd_i and carry_nxt_o = carry_o.
- R7: Operation codes 2 to 5 leave the carry unchanged, so carry_nxt_o = carry_o.
- R8: On a clock edge with carry_we_i high, carry_o takes the value of carry_nxt_o. With carry_we_i low, carry_o holds its value whatever operation is applied.
- R9: zero_o is 1 exactly when acc_i is all zeros, for any operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the carry flag |
| acc_i | input | W | Current accumulator value |
| opnd_i | input | W | Second operand (immediate or register) |
| op_i | input | 3 | Operation code |
| carry_we_i | input | 1 | Load the computed carry into the flag |
| res_o | output | W | Next accumulator value |
| carry_nxt_o | output | 1 | Computed carry |
| carry_o | output | 1 | Stored carry flag |
| zero_o | output | 1 | Accumulator is zero |

## Verification
The bench builds the block with the default width of 8. This puts the full byte carry chain within reach. The add sweep covers every operand value against sixteen accumulator values, including 0x00 and 0xFF, with both stored carry values. This exercises the carry-out boundary at 0xFF + 0x00 + 1 as well as sums that do not overflow. The 8-bit width also makes the half swap a true nibble exchange. The flag tests load and hold the carry through the write enable, so the stored carry that feeds the next add is checked as well.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 3'd0,
    OP_ADDC = 3'd1,
    OP_OR   = 3'd2,
    OP_AND  = 3'd3,
    OP_XOR  = 3'd4,
    OP_SWAP = 3'd5,
    OP_CLRC = 3'd6,
    OP_SETC = 3'd7
  } alu_op_e;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;

  assign c[0] = cin_i;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic p;
    assign p         = a_i[gi] ^ b_i[gi];
    assign sum_o[gi] = p ^ c[gi];
    assign c[gi+1]   = (a_i[gi] & b_i[gi]) | (p & c[gi]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned HALF = W / 2;

  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SWAP: res_o = {a_i[HALF-1:0], a_i[W-1:HALF]};
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_flag.sv
module acc_alu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    acc_i,
  input  logic [W-1:0]    opnd_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_we_i,
  output logic [W-1:0]    res_o,
  output logic            carry_nxt_o,
  output logic            carry_o,
  output logic            zero_o
);
  alu_op_e      op;
  logic [W-1:0] sum;
  logic         cout;
  logic [W-1:0] logic_res;

  assign op = alu_op_e'(op_i);

  acc_alu_adder #(.W(W)) u_add (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (carry_o),
    .sum_o (sum),
    .cout_o(cout)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op_i (op),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .res_o(logic_res)
  );

  always_comb begin
    res_o       = acc_i;
    carry_nxt_o = carry_o;
    unique case (op)
      OP_PASS: res_o = opnd_i;
      OP_ADDC: begin
        res_o       = sum;
        carry_nxt_o = cout;
      end
      OP_OR, OP_AND, OP_XOR, OP_SWAP: res_o = logic_res;
      OP_CLRC: carry_nxt_o = 1'b0;
      OP_SETC: carry_nxt_o = 1'b1;
      default: ;
    endcase
  end

  acc_alu_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (carry_we_i),
    .d_i   (carry_nxt_o),
    .q_o   (carry_o)
  );

  assign zero_o = ~|acc_i;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic [2:0]   op_i,
  input logic         carry_we_i,
  input logic [W-1:0] res_o,
  input logic         carry_nxt_o,
  input logic         carry_o,
  input logic         zero_o
);
  localparam int unsigned HALF = W / 2;

  // R1
  reset_carry_chk: assert property (@(posedge clk_i) !rst_ni |-> !carry_o);

  // R2
  addc_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd1 |-> {carry_nxt_o, res_o} == ({1'b0, acc_i} + {1'b0, opnd_i} + (W+1)'(carry_o)));

  // R4
  swap_halves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd5 |-> res_o == {acc_i[HALF-1:0], acc_i[W-1:HALF]});

  // R5
  setc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd7 |-> carry_nxt_o && res_o == acc_i);

  // R5
  clrc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd6 |-> !carry_nxt_o && res_o == acc_i);

  // R7
  logic_keeps_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 3'd2 && op_i <= 3'd5) |-> carry_nxt_o == carry_o);

  // R8
  carry_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_we_i |=> carry_o == $past(carry_nxt_o));

  // R8
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_we_i |=> $stable(carry_o));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_i      (acc_i),
  .opnd_i     (opnd_i),
  .op_i       (op_i),
  .carry_we_i (carry_we_i),
  .res_o      (res_o),
  .carry_nxt_o(carry_nxt_o),
  .carry_o    (carry_o),
  .zero_o     (zero_o)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] acc_i = '0;
  logic [W-1:0] opnd_i = '0;
  logic [2:0]   op_i = 3'd0;
  logic         carry_we_i = 1'b0;
  logic [W-1:0] res_o;
  logic         carry_nxt_o;
  logic         carry_o;
  logic         zero_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  acc_alu #(.W(W)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = b; carry_we_i = 1'b0;
    #1;
  endtask

  task automatic set_carry(input logic v);
    @(negedge clk_i);
    op_i = v ? 3'd7 : 3'd6; carry_we_i = 1'b1;
    @(posedge clk_i); #1;
    carry_we_i = 1'b0;
    check("R8 carry load", int'(carry_o), int'(v));
  endtask

  task automatic t_reset();
    #1;
    check("R1 carry in reset", int'(carry_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 carry after release", int'(carry_o), 0);
  endtask

  task automatic t_pass();
    for (int c = 0; c < 2; c++) begin
      set_carry(c[0]);
      apply(3'd0, 8'h3C, 8'hA5);
      check("R6 pass result", int'(res_o), 'hA5);
      check("R6 pass carry", int'(carry_nxt_o), c);
    end
  endtask

  task automatic t_addc();
    for (int c = 0; c < 2; c++) begin
      set_carry(c[0]);
      for (int a = 0; a < 256; a += 17) begin
        for (int b = 0; b < 256; b++) begin
          apply(3'd1, a[7:0], b[7:0]);
          check("R2 addc", int'({carry_nxt_o, res_o}), a + b + c);
        end
      end
    end
    set_carry(1'b1);
    apply(3'd1, 8'hFF, 8'h00);
    check("R2 addc boundary", int'({carry_nxt_o, res_o}), 'h100);
  endtask

  task automatic t_logic();
    logic [W-1:0] pa [3] = '{8'hF0, 8'h5A, 8'h00};
    logic [W-1:0] pb [3] = '{8'h3C, 8'hFF, 8'h81};
    for (int c = 0; c < 2; c++) begin
      set_carry(c[0]);
      for (int i = 0; i < 3; i++) begin
        apply(3'd2, pa[i], pb[i]);
        check("R3 or", int'(res_o), int'(pa[i] | pb[i]));
        check("R7 or carry", int'(carry_nxt_o), c);
        apply(3'd3, pa[i], pb[i]);
        check("R3 and", int'(res_o), int'(pa[i] & pb[i]));
        check("R7 and carry", int'(carry_nxt_o), c);
        apply(3'd4, pa[i], pb[i]);
        check("R3 xor", int'(res_o), int'(pa[i] ^ pb[i]));
        check("R7 xor carry", int'(carry_nxt_o), c);
      end
    end
  endtask

  task automatic t_swap();
    for (int c = 0; c < 2; c++) begin
      set_carry(c[0]);
      apply(3'd5, 8'h1E, 8'h77);
      check("R4 swap", int'(res_o), 'hE1);
      check("R7 swap carry", int'(carry_nxt_o), c);
      apply(3'd5, 8'hA0, 8'h00);
      check("R4 swap", int'(res_o), 'h0A);
    end
  endtask

  task automatic t_carry_ops();
    set_carry(1'b1);
    apply(3'd6, 8'h42, 8'h99);
    check("R5 clr carry", int'(carry_nxt_o), 0);
    check("R5 clr keeps acc", int'(res_o), 'h42);
    set_carry(1'b0);
    apply(3'd7, 8'hC3, 8'h11);
    check("R5 set carry", int'(carry_nxt_o), 1);
    check("R5 set keeps acc", int'(res_o), 'hC3);
  endtask

  task automatic t_hold();
    set_carry(1'b1);
    @(negedge clk_i);
    op_i = 3'd6; carry_we_i = 1'b0;
    @(posedge clk_i); #1;
    check("R8 hold after clr", int'(carry_o), 1);
    set_carry(1'b0);
    @(negedge clk_i);
    op_i = 3'd1; acc_i = 8'hFF; opnd_i = 8'hFF; carry_we_i = 1'b0;
    @(posedge clk_i); #1;
    check("R8 hold after add", int'(carry_o), 0);
    @(negedge clk_i);
    carry_we_i = 1'b1;
    @(posedge clk_i); #1;
    carry_we_i = 1'b0;
    check("R8 load add carry", int'(carry_o), 1);
  endtask

  task automatic t_zero();
    for (int op = 0; op < 8; op++) begin
      apply(op[2:0], 8'h00, 8'h55);
      check("R9 zero set", int'(zero_o), 1);
      apply(op[2:0], 8'h80, 8'h00);
      check("R9 zero clear", int'(zero_o), 0);
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_addc();
    t_logic();
    t_swap();
    t_carry_ops();
    t_hold();
    t_zero();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule